// File: doc/BRIEF.md
# MSI-X Interrupt Message Generator

This block turns an internal interrupt request, tagged with a vector index, into an MSI-X message descriptor. With each request it receives the fields of the matching vector-table entry, taken from storage outside the block: the message address, the message data and the vector control word. It checks the function-level gating state and the per-vector mask. When the request passes every gate, it emits a one-cycle pulse that carries an 8-bit destination ID and an 8-bit interrupt vector. A downstream transport turns that pulse into a bus write.

The block also holds the writable enable and function-mask bits of the capability's message control register. It builds the full 16-bit register value, including the read-only table-size field. Software writes to message control reach the block as a write strobe plus data. Only the two writable bits are captured.

Top module: `msixg_top`

## Requirements
- R1: After reset, `msg_valid` is 0, the captured enable and function-mask bits are 0, and `ctl_value` reads `NUM_VEC-1` in bits 10:0 and zero elsewhere.
- R2: On a clock edge where `ctl_wr_en` is 1, bit 15 of `ctl_wr_data` becomes the MSI-X enable and bit 14 becomes the function mask. The new values show in `ctl_value` bits 15 and 14 from the next cycle. All other written bits are ignored. A request in the same cycle as the write is judged with the old values.
- R3: `ctl_value` bits 10:0 always equal `NUM_VEC-1`, and bits 13:11 always read 0.
- R4: No message is issued unless the captured enable bit is 1 and `msi_en` is 0 in the request cycle.
- R5: No message is issued while the captured function-mask bit is 1.
- R6: A request with `req_index` >= `NUM_VEC` is dropped.
- R7: A request whose `ent_vctrl` bit 0 (per-vector mask) is 1 is dropped.
- R8: An issued message carries `msg_dest` = `ent_addr[19:12]` and `msg_vector` = `ent_data[7:0]` from the request cycle.
- R9: An accepted request raises `msg_valid` for exactly the next cycle. Requests in consecutive cycles each give their own pulse.
- R10: A dropped request is not held pending. Clearing a mask later produces no message until a new request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_en | input | 1 | Software write strobe for message control |
| ctl_wr_data | input | 16 | Message control write data |
| msi_en | input | 1 | Plain MSI enable bit |
| req_valid | input | 1 | Interrupt request strobe |
| req_index | input | IDX_W | Vector index of the request |
| ent_addr | input | 32 | Table entry message address |
| ent_data | input | 32 | Table entry message data |
| ent_vctrl | input | 32 | Table entry vector control |
| msg_valid | output | 1 | One-cycle message pulse |
| msg_dest | output | 8 | Destination ID of the message |
| msg_vector | output | 8 | Interrupt vector of the message |
| ctl_value | output | 16 | Full message control register value |

## Verification
Requests are applied in several ways:
- With each gating input failing alone (enable off, plain MSI on, function mask set, index at the count and at the top of the index range, per-vector mask set). This tells the gates apart from one another.
- Against a vector control word that has every bit set except the mask. This shows that only bit 0 counts.
- Back to back with distinct address and data patterns. This separates field extraction from the pulse timing.
- In the same cycle as a control write, which shows whether old or new gating state applies.
- After a blocked request whose mask is later cleared. This exposes any leftover pending state.

// File: rtl/msixg_pkg.sv
package msixg_pkg;

    localparam int CTL_W     = 16;
    localparam int EN_BIT    = 15;
    localparam int FMASK_BIT = 14;
    localparam int TSIZE_W   = 11;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int DEST_LSB  = 12;
    localparam int FIELD_W   = 8;

    typedef struct packed {
        logic enable;
        logic fmask;
    } ctl_state_t;

    typedef struct packed {
        logic [FIELD_W-1:0] dest;
        logic [FIELD_W-1:0] vector;
    } msg_t;

    function automatic msg_t extract_msg(input logic [ADDR_W-1:0] addr,
                                         input logic [DATA_W-1:0] data);
        msg_t m;
        m.dest   = addr[DEST_LSB +: FIELD_W];
        m.vector = data[FIELD_W-1:0];
        return m;
    endfunction

    function automatic logic [CTL_W-1:0] pack_ctl(input ctl_state_t s,
                                                  input logic [TSIZE_W-1:0] tsize);
        logic [CTL_W-1:0] v;
        v                = '0;
        v[EN_BIT]        = s.enable;
        v[FMASK_BIT]     = s.fmask;
        v[TSIZE_W-1:0]   = tsize;
        return v;
    endfunction

endpackage

// File: rtl/msixg_ctl_reg.sv
module msixg_ctl_reg
    import msixg_pkg::*;
#(
    parameter int NUM_VEC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output ctl_state_t       state,
    output logic [CTL_W-1:0] value
);
    localparam logic [TSIZE_W-1:0] TSIZE = TSIZE_W'(NUM_VEC - 1);

    ctl_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (wr_en) begin
            state_q.enable <= wr_data[EN_BIT];
            state_q.fmask  <= wr_data[FMASK_BIT];
        end
    end

    assign state = state_q;
    assign value = pack_ctl(state_q, TSIZE);

endmodule

// File: rtl/msixg_gate.sv
module msixg_gate
    import msixg_pkg::*;
#(
    parameter int NUM_VEC = 3,
    parameter int IDX_W   = 11
) (
    input  ctl_state_t        state,
    input  logic              msi_en,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [ADDR_W-1:0] ent_addr,
    input  logic [DATA_W-1:0] ent_data,
    input  logic [DATA_W-1:0] ent_vctrl,
    output logic              accept,
    output msg_t              msg
);
    localparam logic [IDX_W:0] COUNT = (IDX_W+1)'(NUM_VEC);

    logic fn_active;
    logic in_range;
    logic vec_open;

    always_comb begin
        fn_active = state.enable && !msi_en && !state.fmask;
        in_range  = {1'b0, req_index} < COUNT;
        vec_open  = !ent_vctrl[0];
        accept    = req_valid && fn_active && in_range && vec_open;
        msg       = extract_msg(ent_addr, ent_data);
    end

endmodule

// File: rtl/msixg_out.sv
module msixg_out
    import msixg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  msg_t msg_in,
    output logic valid,
    output msg_t msg_out
);
    logic valid_q;
    msg_t msg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            msg_q   <= '0;
        end else begin
            valid_q <= accept;
            if (accept) begin
                msg_q <= msg_in;
            end
        end
    end

    assign valid   = valid_q;
    assign msg_out = msg_q;

endmodule

// File: rtl/msixg_top.sv
module msixg_top
    import msixg_pkg::*;
#(
    parameter int NUM_VEC = 3,
    parameter int IDX_W   = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr_en,
    input  logic [15:0]       ctl_wr_data,
    input  logic              msi_en,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [31:0]       ent_addr,
    input  logic [31:0]       ent_data,
    input  logic [31:0]       ent_vctrl,
    output logic              msg_valid,
    output logic [7:0]        msg_dest,
    output logic [7:0]        msg_vector,
    output logic [15:0]       ctl_value
);
    ctl_state_t state;
    logic       accept;
    msg_t       msg_c;
    msg_t       msg_r;

    msixg_ctl_reg #(.NUM_VEC(NUM_VEC)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctl_wr_en),
        .wr_data (ctl_wr_data),
        .state   (state),
        .value   (ctl_value)
    );

    msixg_gate #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_gate (
        .state     (state),
        .msi_en    (msi_en),
        .req_valid (req_valid),
        .req_index (req_index),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .ent_vctrl (ent_vctrl),
        .accept    (accept),
        .msg       (msg_c)
    );

    msixg_out u_out (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .msg_in  (msg_c),
        .valid   (msg_valid),
        .msg_out (msg_r)
    );

    assign msg_dest   = msg_r.dest;
    assign msg_vector = msg_r.vector;

endmodule

// File: rtl/msixg_checks.sv
module msixg_checks #(
    parameter int NUM_VEC = 3,
    parameter int IDX_W   = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             msi_en,
    input logic             req_valid,
    input logic [IDX_W-1:0] req_index,
    input logic [31:0]      ent_addr,
    input logic [31:0]      ent_data,
    input logic [31:0]      ent_vctrl,
    input logic             msg_valid,
    input logic [7:0]       msg_dest,
    input logic [7:0]       msg_vector,
    input logic [15:0]      ctl_value
);
    localparam logic [IDX_W:0]  COUNT = (IDX_W+1)'(NUM_VEC);
    localparam logic [10:0]     TSIZE = 11'(NUM_VEC - 1);

    p_ro_fields_r3: assert property (@(posedge clk) disable iff (rst)
        ctl_value[10:0] == TSIZE && ctl_value[13:11] == 3'b000);

    p_needs_enable_r4: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> ($past(ctl_value[15]) && !$past(msi_en)));

    p_fmask_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> !$past(ctl_value[14]));

    p_index_range_r6: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> ({1'b0, $past(req_index)} < COUNT));

    p_vec_mask_r7: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> !$past(ent_vctrl[0]));

    p_fields_r8: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_dest == $past(ent_addr[19:12]) &&
                       msg_vector == $past(ent_data[7:0])));

    p_pulse_from_req_r9: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> $past(req_valid));

endmodule

bind msixg_top msixg_checks #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_checks (
    .clk        (clk),
    .rst        (rst),
    .msi_en     (msi_en),
    .req_valid  (req_valid),
    .req_index  (req_index),
    .ent_addr   (ent_addr),
    .ent_data   (ent_data),
    .ent_vctrl  (ent_vctrl),
    .msg_valid  (msg_valid),
    .msg_dest   (msg_dest),
    .msg_vector (msg_vector),
    .ctl_value  (ctl_value)
);

// File: tb/tb_msixg_top.sv
module tb_msixg_top;
    localparam int NUM_VEC = 3;
    localparam int IDX_W   = 11;

    logic             clk = 1'b0;
    logic             rst;
    logic             ctl_wr_en;
    logic [15:0]      ctl_wr_data;
    logic             msi_en;
    logic             req_valid;
    logic [IDX_W-1:0] req_index;
    logic [31:0]      ent_addr;
    logic [31:0]      ent_data;
    logic [31:0]      ent_vctrl;
    logic             msg_valid;
    logic [7:0]       msg_dest;
    logic [7:0]       msg_vector;
    logic [15:0]      ctl_value;

    always #4 clk = ~clk;

    msixg_top #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst(rst), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .msi_en(msi_en), .req_valid(req_valid), .req_index(req_index),
        .ent_addr(ent_addr), .ent_data(ent_data), .ent_vctrl(ent_vctrl),
        .msg_valid(msg_valid), .msg_dest(msg_dest), .msg_vector(msg_vector),
        .ctl_value(ctl_value)
    );

    int vectors  = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    bit        m_en, m_fm;
    bit        e_valid;
    bit [7:0]  e_dest, e_vec;
    int        pulses_seen;

    function automatic bit [15:0] exp_ctl();
        return {m_en, m_fm, 3'b000, 11'(NUM_VEC - 1)};
    endfunction

    task automatic fail_line(string tag, string what, int act, int exp);
        failures++;
        $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    endtask

    task automatic compare(string tag);
        vectors++;
        if (msg_valid !== e_valid) fail_line(tag, "msg_valid", msg_valid, e_valid);
        if (e_valid && msg_valid === 1'b1) begin
            if (msg_dest !== e_dest)  fail_line(tag, "msg_dest", msg_dest, e_dest);
            if (msg_vector !== e_vec) fail_line(tag, "msg_vector", msg_vector, e_vec);
        end
        if (ctl_value !== exp_ctl()) fail_line(tag, "ctl_value", ctl_value, exp_ctl());
        if (msg_valid === 1'b1) pulses_seen++;
    endtask

    // one clock: inputs already applied; model evaluates at the edge, compare at negedge
    task automatic cyc(string tag);
        bit acc;
        @(posedge clk);
        if (rst) begin
            e_valid = 0; m_en = 0; m_fm = 0;
        end else begin
            acc = req_valid && m_en && !msi_en && !m_fm &&
                  (int'(req_index) < NUM_VEC) && !ent_vctrl[0];
            e_valid = acc;
            if (acc) begin
                e_dest = ent_addr[19:12];
                e_vec  = ent_data[7:0];
            end
            if (ctl_wr_en) begin
                m_en = ctl_wr_data[15];
                m_fm = ctl_wr_data[14];
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle();
        ctl_wr_en = 0; req_valid = 0;
    endtask

    task automatic wr_ctl(logic [15:0] d, string tag);
        idle();
        ctl_wr_en = 1; ctl_wr_data = d;
        cyc(tag);
        ctl_wr_en = 0;
    endtask

    task automatic req(int idx, logic [31:0] a, logic [31:0] d, logic [31:0] vc, string tag);
        req_valid = 1; req_index = IDX_W'(idx);
        ent_addr = a; ent_data = d; ent_vctrl = vc;
        cyc(tag);
        req_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; ctl_wr_en = 0; ctl_wr_data = 0; msi_en = 0;
        req_valid = 0; req_index = 0; ent_addr = 0; ent_data = 0; ent_vctrl = 0;
        m_en = 0; m_fm = 0; e_valid = 0; e_dest = 0; e_vec = 0; pulses_seen = 0;
        @(negedge clk);
        cyc("R1");
        cyc("R1");
        rst = 0;
        cyc("R1");
        cyc("R3");

        // R4: disabled function
        req(0, 32'h000AB000, 32'h0000_0034, 32'h0, "R4");
        cyc("R4");

        // R2: write all ones, only bits 15/14 captured; R5 fmask blocks
        wr_ctl(16'hFFFF, "R2");
        cyc("R2");
        req(1, 32'h00011000, 32'h0000_0022, 32'h0, "R5");
        cyc("R5");

        // enable, unmask
        wr_ctl(16'h8000, "R2");
        req(0, 32'h000AB000, 32'h0000_1234, 32'h0, "R8");
        cyc("R9");

        // R4: plain MSI on
        msi_en = 1;
        req(0, 32'h000CD000, 32'h0000_0056, 32'h0, "R4");
        cyc("R4");
        msi_en = 0;

        // R6: range
        req(3, 32'h000EE000, 32'h0000_0077, 32'h0, "R6");
        cyc("R6");
        req(2, 32'hFFF5A000, 32'hFFFF_FF99, 32'h0, "R6");
        cyc("R6");
        req(2047, 32'h00033000, 32'h0000_0011, 32'h0, "R6");
        cyc("R6");

        // R7: per-vector mask, only bit 0 matters
        req(1, 32'h00044000, 32'h0000_0044, 32'h0000_0001, "R7");
        cyc("R7");
        req(1, 32'h00045000, 32'h0000_0045, 32'hFFFF_FFFE, "R7");
        cyc("R7");

        // R9: back to back
        for (int i = 0; i < 5; i++) begin
            req_valid = 1; req_index = IDX_W'(i % NUM_VEC);
            ent_addr = 32'((i * 37 + 5) << 12) | 32'h00F00FFF;
            ent_data = 32'(i * 51 + 3) | 32'hABCD_0000;
            ent_vctrl = 32'h0;
            cyc("R9");
        end
        req_valid = 0;
        cyc("R9");
        cyc("R9");

        // R10: blocked by fmask, then unmask, no late message
        wr_ctl(16'hC000, "R2");
        req(0, 32'h00066000, 32'h0000_0066, 32'h0, "R10");
        wr_ctl(16'h8000, "R10");
        pulses_seen = 0;
        repeat (4) cyc("R10");
        vectors++;
        if (pulses_seen != 0) fail_line("R10", "late pulses", pulses_seen, 0);

        // R2: request in same cycle as write uses old state
        ctl_wr_en = 1; ctl_wr_data = 16'h0000;
        req(1, 32'h00077000, 32'h0000_0088, 32'h0, "R2");
        ctl_wr_en = 0;
        req(1, 32'h00078000, 32'h0000_0089, 32'h0, "R2");
        cyc("R2");
        ctl_wr_en = 1; ctl_wr_data = 16'h8000;
        req(2, 32'h00079000, 32'h0000_008A, 32'h0, "R2");
        ctl_wr_en = 0;
        cyc("R2");

        // R1: reset mid-run
        rst = 1;
        req(0, 32'h0007A000, 32'h0000_008B, 32'h0, "R1");
        rst = 0;
        cyc("R1");
        req(0, 32'h0007B000, 32'h0000_008C, 32'h0, "R1");
        cyc("R1");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end

endmodule